// File: doc/BRIEF.md
# DRAM Controller Glue Sequencer

This block sits between a processor bus and a DRAM controller/driver that has an automatic-access mode and a forced-refresh mode. It watches the processor's cycle-start strobe, the read/write direction, the address decode and a write-data-ready flag. From these it drives the controller's row-strobe request (active low), its chip enable and its mode select, and it returns a hold (wait) signal to the processor.

Every processor cycle gets a row-strobe pulse, including cycles that do not hit this memory. A non-local cycle runs with the enable low, so that the controller can hide a refresh behind it. A read is launched as soon as the cycle is known. A write is launched only once the bus reports that its data is ready. When the controller raises a refresh request, the sequencer holds it until the current access is finished and then puts the controller into forced-refresh mode for a fixed number of cycles. A fixed gap follows before the next access. A local cycle that arrives during the refresh or the gap is held off with the wait signal, and reads also get a fixed number of wait states during the strobe.

Top module: `dram_glue_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `ctl_row_strobe_n` is 1, `ctl_force_refresh` is 0, `ctl_enable` is 0 and `cpu_hold` is 0.
- R2: A read with no refresh pending drives `ctl_row_strobe_n` low three cycles after the clock edge that samples `cpu_start`. It stays low for exactly `RAS_CYC` cycles.
- R3: For a write, `ctl_row_strobe_n` falls no earlier than in the case of R2. It also falls no earlier than the cycle after the first edge that samples `cpu_wdata_ok` high.
- R4: A cycle with `cpu_local` = 0 still produces one row-strobe pulse of `RAS_CYC` cycles. For that cycle `ctl_enable` and `cpu_hold` stay 0 throughout.
- R5: For a local read, `cpu_hold` is 1 during the first min(`READ_WAITS`, `RAS_CYC`) cycles of the row strobe. No write ever raises `cpu_hold` while its row strobe is low.
- R6: A one-cycle `ctl_refresh_req` pulse leads to `ctl_force_refresh` = 1 (1 = forced refresh, 0 = automatic access) for exactly `REF_CYC` cycles. The row strobe is never low while it is 1.
- R7: A refresh request that arrives while the row strobe is low is held. `ctl_force_refresh` rises one cycle after `ctl_row_strobe_n` returns high.
- R8: A local cycle started during a refresh or during the gap that follows it gets `cpu_hold` = 1 from the cycle after its start until the gap ends. That is `REF_CYC` + `GAP_CYC` cycles when it starts together with the request.
- R9: After `ctl_force_refresh` falls, at least `GAP_CYC` + 2 cycles pass before `ctl_row_strobe_n` falls. Exactly that many pass for a read waiting on the refresh.
- R10: If `cpu_start` and `ctl_refresh_req` arrive in the same cycle, the refresh goes first. `ctl_force_refresh` rises two cycles after that edge.
- R11: `ctl_enable` equals `cpu_local` in the cycle before the row strobe falls and keeps that value for the whole strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_start | input | 1 | One-cycle pulse: processor bus cycle begins |
| cpu_write | input | 1 | 1 = write, 0 = read; valid with `cpu_start` |
| cpu_local | input | 1 | Address decode hit for this memory; valid with `cpu_start` |
| cpu_wdata_ok | input | 1 | Write data will meet the column-strobe setup time |
| ctl_refresh_req | input | 1 | One-cycle refresh request pulse from the controller |
| ctl_row_strobe_n | output | 1 | Row-strobe request to the controller, active low |
| ctl_force_refresh | output | 1 | Mode select: 1 = forced refresh, 0 = automatic access |
| ctl_enable | output | 1 | Controller chip enable for a local access |
| cpu_hold | output | 1 | Wait request to the processor |

## Verification
The properties take for granted that the processor issues a new `cpu_start` only after the previous row strobe has ended. They also assume that `cpu_write` and `cpu_local` hold their values for the whole cycle, and that `ctl_refresh_req` is a single-cycle pulse that never arrives while a refresh is already pending. The stimulus keeps within these limits by running one operation at a time with an idle tail long enough for any refresh and gap to finish. It raises refresh pulses only together with a start or once per strobe, and it randomises only the direction, the decode, the write-data delay and which of these refresh placements is used.

// File: rtl/glue_pkg.sv
package glue_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_ACCESS  = 3'd2,
        ST_REFRESH = 3'd3,
        ST_GAP     = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic wr;
        logic hit;
    } cyc_info_t;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic refresh_side(input seq_state_e s);
        return (s == ST_REFRESH) || (s == ST_GAP);
    endfunction

endpackage

// File: rtl/glue_cap.sv
module glue_cap
    import glue_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cpu_start,
    input  logic      cpu_write,
    input  logic      cpu_local,
    input  logic      refresh_req,
    input  logic      take_cyc,
    input  logic      take_ref,
    output logic      cyc_pend,
    output logic      ref_pend,
    output cyc_info_t cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_pend <= 1'b0;
            ref_pend <= 1'b0;
            cur      <= '0;
        end else begin
            cyc_pend <= (cyc_pend & ~take_cyc) | cpu_start;
            ref_pend <= (ref_pend & ~take_ref) | refresh_req;
            if (cpu_start) begin
                cur.wr  <= cpu_write;
                cur.hit <= cpu_local;
            end
        end
    end
endmodule

// File: rtl/glue_fsm.sv
module glue_fsm
    import glue_pkg::*;
#(
    parameter int unsigned RAS_CYC = 4,
    parameter int unsigned REF_CYC = 5,
    parameter int unsigned GAP_CYC = 2,
    parameter int unsigned CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_pend,
    input  logic             ref_pend,
    input  logic             cur_wr,
    input  logic             wdata_ok,
    output seq_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             take_cyc,
    output logic             take_ref
);
    localparam logic [CNT_W-1:0] RAS_LAST = CNT_W'(RAS_CYC - 1);
    localparam logic [CNT_W-1:0] REF_LAST = CNT_W'(REF_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

    seq_state_e       nxt;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        nxt      = state;
        cnt_nxt  = cnt;
        take_cyc = 1'b0;
        take_ref = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend) begin
                    nxt      = ST_REFRESH;
                    cnt_nxt  = '0;
                    take_ref = 1'b1;
                end else if (cyc_pend) begin
                    nxt      = ST_SETUP;
                    take_cyc = 1'b1;
                end
            end
            ST_SETUP: begin
                if (!cur_wr || wdata_ok) begin
                    nxt     = ST_ACCESS;
                    cnt_nxt = '0;
                end
            end
            ST_ACCESS: begin
                if (cnt == RAS_LAST) nxt = ST_IDLE;
                else                 cnt_nxt = cnt + CNT_W'(1);
            end
            ST_REFRESH: begin
                if (cnt == REF_LAST) begin
                    nxt     = ST_GAP;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (cnt == GAP_LAST) nxt = ST_IDLE;
                else                 cnt_nxt = cnt + CNT_W'(1);
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end
endmodule

// File: rtl/glue_out.sv
module glue_out
    import glue_pkg::*;
#(
    parameter int unsigned READ_WAITS = 2,
    parameter int unsigned CNT_W      = 3
) (
    input  seq_state_e       state,
    input  logic [CNT_W-1:0] cnt,
    input  cyc_info_t        cur,
    input  logic             cyc_pend,
    output logic             row_strobe_n,
    output logic             force_refresh,
    output logic             enable,
    output logic             hold
);
    logic blocked;
    logic rd_ws;

    assign row_strobe_n  = (state != ST_ACCESS);
    assign force_refresh = (state == ST_REFRESH);
    assign enable        = cur.hit && ((state == ST_SETUP) || (state == ST_ACCESS));
    assign blocked       = cyc_pend && cur.hit && refresh_side(state);

    generate
        if (READ_WAITS == 0) begin : g_no_ws
            assign rd_ws = 1'b0;
        end else begin : g_ws
            assign rd_ws = (state == ST_ACCESS) && cur.hit && !cur.wr &&
                           (cnt < CNT_W'(READ_WAITS));
        end
    endgenerate

    assign hold = blocked || rd_ws;
endmodule

// File: rtl/dram_glue_seq.sv
module dram_glue_seq
    import glue_pkg::*;
#(
    parameter int unsigned RAS_CYC    = 4,
    parameter int unsigned READ_WAITS = 2,
    parameter int unsigned REF_CYC    = 5,
    parameter int unsigned GAP_CYC    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_start,
    input  logic cpu_write,
    input  logic cpu_local,
    input  logic cpu_wdata_ok,
    input  logic ctl_refresh_req,
    output logic ctl_row_strobe_n,
    output logic ctl_force_refresh,
    output logic ctl_enable,
    output logic cpu_hold
);
    localparam int unsigned CNT_MAX = max4(RAS_CYC, READ_WAITS, REF_CYC, GAP_CYC);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    cyc_info_t        cur_q;
    logic             cyc_pend;
    logic             ref_pend;
    logic             take_cyc;
    logic             take_ref;

    glue_cap u_cap (
        .clk         (clk),
        .rst         (rst),
        .cpu_start   (cpu_start),
        .cpu_write   (cpu_write),
        .cpu_local   (cpu_local),
        .refresh_req (ctl_refresh_req),
        .take_cyc    (take_cyc),
        .take_ref    (take_ref),
        .cyc_pend    (cyc_pend),
        .ref_pend    (ref_pend),
        .cur         (cur_q)
    );

    glue_fsm #(
        .RAS_CYC (RAS_CYC),
        .REF_CYC (REF_CYC),
        .GAP_CYC (GAP_CYC),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cyc_pend (cyc_pend),
        .ref_pend (ref_pend),
        .cur_wr   (cur_q.wr),
        .wdata_ok (cpu_wdata_ok),
        .state    (state),
        .cnt      (cnt),
        .take_cyc (take_cyc),
        .take_ref (take_ref)
    );

    glue_out #(
        .READ_WAITS (READ_WAITS),
        .CNT_W      (CNT_W)
    ) u_out (
        .state         (state),
        .cnt           (cnt),
        .cur           (cur_q),
        .cyc_pend      (cyc_pend),
        .row_strobe_n  (ctl_row_strobe_n),
        .force_refresh (ctl_force_refresh),
        .enable        (ctl_enable),
        .hold          (cpu_hold)
    );
endmodule

// File: rtl/glue_seq_chk.sv
module glue_seq_chk #(
    parameter int unsigned RAS_CYC = 4,
    parameter int unsigned REF_CYC = 5,
    parameter int unsigned GAP_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic force_ref,
    input logic en,
    input logic hold,
    input logic wdata_ok,
    input logic cur_wr
);
    logic [7:0] run_low;
    logic [7:0] run_ref;
    logic [7:0] since_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_low   <= '0;
            run_ref   <= '0;
            since_ref <= 8'(GAP_CYC);
        end else begin
            run_low <= ras_n ? 8'd0 : run_low + 8'd1;
            run_ref <= force_ref ? run_ref + 8'd1 : 8'd0;
            if (force_ref)                   since_ref <= 8'd0;
            else if (since_ref < 8'(GAP_CYC)) since_ref <= since_ref + 8'd1;
        end
    end

    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(force_ref && !ras_n));

    p_ref_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(force_ref) |-> run_ref == 8'(REF_CYC));

    p_ras_len_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> run_low == 8'(RAS_CYC));

    p_ref_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(force_ref) |-> ($past(ras_n) && ras_n));

    p_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> since_ref >= 8'(GAP_CYC));

    p_wr_data_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && cur_wr) |-> $past(wdata_ok));

    p_wr_nowait_r5: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && cur_wr) |-> !hold);

    p_en_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> $stable(en));
endmodule

bind dram_glue_seq glue_seq_chk #(
    .RAS_CYC (RAS_CYC),
    .REF_CYC (REF_CYC),
    .GAP_CYC (GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ctl_row_strobe_n),
    .force_ref (ctl_force_refresh),
    .en        (ctl_enable),
    .hold      (cpu_hold),
    .wdata_ok  (cpu_wdata_ok),
    .cur_wr    (cur_q.wr)
);

// File: tb/sim_dram_glue_seq.sv
`timescale 1ns/100ps
module sim_dram_glue_seq;
    localparam int RAS = 4;
    localparam int RW  = 2;
    localparam int REF = 5;
    localparam int GAP = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, wr = 1'b0, loc = 1'b0, wok = 1'b0, req = 1'b0;
    logic ras_n, force_r, en, hold;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    dram_glue_seq #(
        .RAS_CYC (RAS), .READ_WAITS (RW), .REF_CYC (REF), .GAP_CYC (GAP)
    ) u0 (
        .clk (clk), .rst (rst), .cpu_start (start), .cpu_write (wr),
        .cpu_local (loc), .cpu_wdata_ok (wok), .ctl_refresh_req (req),
        .ctl_row_strobe_n (ras_n), .ctl_force_refresh (force_r),
        .ctl_enable (en), .cpu_hold (hold)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // observation index of the first low row strobe, counted from the start drive
    function automatic int exp_fall(input bit w, input int d, input int rm);
        int s;
        s = (rm == 1) ? 3 + REF + GAP : 2;
        return w ? imax(s + 1, d + 1) : s + 1;
    endfunction

    function automatic int exp_rd_waits(input bit w, input bit l);
        return (l && !w) ? imin(RW, RAS) : 0;
    endfunction

    function automatic int exp_block(input bit l, input int rm);
        return (rm == 1 && l) ? REF + GAP : 0;
    endfunction

    // R6: never a low row strobe during forced refresh, seen at the ports
    always @(negedge clk) begin
        if (!rst && !done && force_r && !ras_n)
            chk("R6 strobe during refresh", 1, 0);
    end

    // rm: 0 no refresh, 1 request with start, 2 request during strobe
    task automatic do_op(input string nm, input bit w, input bit l, input int d, input int rm);
        int n, fall, rise, mrise, mfall, low, wlow, wblk, mlen, cs_pre, cs_bad, en_hi, prev_cs;
        n = 3 + 6 + RAS + REF + GAP + 6;
        fall = -1; rise = -1; mrise = -1; mfall = -1;
        low = 0; wlow = 0; wblk = 0; mlen = 0; cs_pre = -1; cs_bad = 0; en_hi = 0;
        prev_cs = int'(en);
        start = 1'b1; wr = w; loc = l; wok = w && (d == 0); req = (rm == 1);
        for (int i = 1; i <= n; i++) begin
            step();
            if (!ras_n && fall < 0) begin fall = i; cs_pre = prev_cs; end
            if (!ras_n) begin
                low++;
                if (hold) wlow++;
                if (int'(en) != int'(l)) cs_bad++;
            end
            if (ras_n && fall >= 0 && rise < 0) rise = i;
            if (fall < 0 && hold) wblk++;
            if (en) en_hi++;
            if (force_r) mlen++;
            if (force_r && mrise < 0) mrise = i;
            if (!force_r && mrise >= 0 && mfall < 0) mfall = i;
            prev_cs = int'(en);
            if (req) req = 1'b0;
            if (i == 1) start = 1'b0;
            if (w && i == d) wok = 1'b1;
            if (rm == 2 && i == fall) req = 1'b1;
        end
        wok = 1'b0;
        if (w) chk({nm, " R3 write strobe fall"}, fall, exp_fall(w, d, rm));
        else   chk({nm, " R2 read strobe fall"}, fall, exp_fall(w, d, rm));
        chk({nm, " R2 strobe length"}, low, RAS);
        chk({nm, " R5 wait states in strobe"}, wlow, exp_rd_waits(w, l));
        chk({nm, " R11 enable before fall"}, cs_pre, int'(l));
        chk({nm, " R11 enable held in strobe"}, cs_bad, 0);
        if (!l) chk({nm, " R4 non-local enable"}, en_hi, 0);
        if (!l) chk({nm, " R4 non-local hold"}, wlow + wblk, 0);
        chk({nm, " R8 hold while blocked"}, wblk, exp_block(l, rm));
        if (rm == 0) chk({nm, " R6 no refresh"}, mlen, 0);
        if (rm != 0) chk({nm, " R6 refresh length"}, mlen, REF);
        if (rm == 1) begin
            chk({nm, " R10 refresh first"}, mrise, 2);
            chk({nm, " R9 gap"}, fall - mfall, exp_fall(w, d, rm) - (2 + REF));
        end
        if (rm == 2) chk({nm, " R7 held request"}, mrise, exp_fall(w, d, rm) + RAS + 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1 reset state
        step();
        chk("R1 ras in reset", int'(ras_n), 1);
        chk("R1 mode in reset", int'(force_r), 0);
        step();
        rst = 1'b0;
        step();
        chk("R1 ras after reset", int'(ras_n), 1);
        chk("R1 mode after reset", int'(force_r), 0);
        chk("R1 enable after reset", int'(en), 0);
        chk("R1 hold after reset", int'(hold), 0);
        // directed corners
        do_op("local read",       1'b0, 1'b1, 0, 0);
        do_op("write data early", 1'b1, 1'b1, 0, 0);
        do_op("write data late",  1'b1, 1'b1, 5, 0);
        do_op("non-local read",   1'b0, 1'b0, 0, 0);
        do_op("non-local write",  1'b1, 1'b0, 3, 0);
        do_op("read vs refresh",  1'b0, 1'b1, 0, 1);
        do_op("write vs refresh", 1'b1, 1'b1, 4, 1);
        do_op("nonlocal vs ref",  1'b0, 1'b0, 0, 1);
        do_op("ref in read",      1'b0, 1'b1, 0, 2);
        do_op("ref in write",     1'b1, 1'b1, 2, 2);
        // constrained random
        for (int k = 0; k < 60; k++) begin
            bit rw, rl;
            int rd, rm;
            rw = 1'($urandom % 2);
            rl = 1'(($urandom % 4) != 0);
            rd = int'($urandom % 7);
            rm = int'($urandom % 3);
            do_op($sformatf("rand%0d", k), rw, rl, rd, rm);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule